// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block is the data path of a small 8-bit processor core: an accumulator, two index registers and a status byte, plus the logic that updates them for two operations, add-with-carry and bitwise AND. Address generation and memory access happen elsewhere. Each clock cycle the surrounding core hands the block one record: an opcode, the operand already fetched from memory, and a two-bit qualifier that says whether the record is to be executed or only carried along.

The record is captured on one clock edge and executed on the next. The updated registers are visible on the outputs after that second edge. The opcode holds an operation group and an addressing-mode index. All eight addressing modes of one operation share a single execution path, because the operand arrives already resolved. Opcodes outside the two groups, and records whose qualifier is not "execute", leave every register unchanged.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, X, Y and the status byte to zero and discards any captured record; while `rst` is high the outputs read zero on the following edge.
- R2: Add-with-carry sets the accumulator to the low 8 bits of A + M + C, where C is status bit 0. Status bit 0 becomes 1 exactly when the 9-bit sum exceeds 255.
- R3: After an executed add or AND, status bit 1 (zero) is 1 exactly when the new accumulator is 0, and status bit 7 (negative) equals accumulator bit 7. Status bits 2 to 6 keep their previous value.
- R4: AND sets the accumulator to A & M and leaves status bit 0 (carry) unchanged.
- R5: Opcode bits [7:3] select the operation: 5'b00010 is add-with-carry and 5'b00100 is AND. Bits [2:0] are the addressing-mode index (0 to 7). All eight indices of one operation give identical results for the same operand.
- R6: A record present at clock edge k is executed at edge k+1, and its effect appears on the outputs only after edge k+1. The first edge after reset is released only captures a record.
- R7: Qualifier 2'b01 executes the record. Qualifier 2'b10 leaves all registers unchanged.
- R8: Qualifiers 2'b00 and 2'b11 are illegal and are treated like 2'b10: no register changes.
- R9: An executed record whose opcode lies outside the two groups of R5 changes no register.
- R10: No operation writes X or Y; `out_x` and `out_y` keep their reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_op | input | 8 | Opcode: operation group in [7:3], addressing mode in [2:0] |
| in_mem | input | DATA_W | Operand already fetched from memory |
| in_kind | input | 2 | Record qualifier: 01 execute, 10 present only, 00/11 illegal |
| out_acc | output | DATA_W | Accumulator |
| out_stat | output | DATA_W | Status: carry bit 0, zero bit 1, negative bit 7 |
| out_x | output | DATA_W | X index register |
| out_y | output | DATA_W | Y index register |

## Verification
The hardest state to reach from the ports is a particular pairing of accumulator value and incoming carry. The accumulator can only be set through the same add and AND operations under test, and the carry depends on whatever ran before. The stimulus therefore builds each operand pair from a short preamble: an AND with zero to clear the accumulator, an add to load the chosen value, and for the AND sweep an add of all-ones to force a carry. A bench model tracks the resulting carry so that every combination of accumulator, operand and carry is compared. Records are streamed back to back with the model applied two records late, so a result that shows up one cycle early or one cycle late is caught on every step.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W   = 8;
    localparam int MODE_W = 3;
    localparam int GRP_W  = OP_W - MODE_W;
    localparam int MODE_N = 1 << MODE_W;

    // Status byte positions that the rest of the core decodes
    localparam int C_POS = 0;
    localparam int Z_POS = 1;

    localparam logic [GRP_W-1:0] GRP_ADD = 5'b00010;
    localparam logic [GRP_W-1:0] GRP_AND = 5'b00100;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'b00,
        KIND_EXEC = 2'b01,
        KIND_SHOW = 2'b10,
        KIND_BAD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        CLS_NOP = 2'b00,
        CLS_ADD = 2'b01,
        CLS_AND = 2'b10
    } cls_e;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output cls_e            cls
);

    logic [MODE_N-1:0] add_hit;
    logic [MODE_N-1:0] and_hit;

    // Every addressing-mode variant maps onto the same class
    for (genvar m = 0; m < MODE_N; m++) begin : g_mode
        assign add_hit[m] = (op == {GRP_ADD, MODE_W'(m)});
        assign and_hit[m] = (op == {GRP_AND, MODE_W'(m)});
    end

    always_comb begin
        if (|add_hit) begin
            cls = CLS_ADD;
        end else if (|and_hit) begin
            cls = CLS_AND;
        end else begin
            cls = CLS_NOP;
        end
    end

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  cls_e              cls,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] acc_nxt,
    output logic [DATA_W-1:0] stat_nxt
);

    localparam int SUM_W = DATA_W + 1;
    localparam int N_POS = DATA_W - 1;

    logic [SUM_W-1:0] sum;

    assign sum = {1'b0, acc} + {1'b0, mem} + SUM_W'(stat[C_POS]);

    always_comb begin
        acc_nxt  = acc;
        stat_nxt = stat;
        unique case (cls)
            CLS_ADD: begin
                acc_nxt         = sum[DATA_W-1:0];
                stat_nxt[C_POS] = sum[DATA_W];
            end
            CLS_AND: begin
                acc_nxt = acc & mem;
            end
            default: begin
                acc_nxt = acc;
            end
        endcase
        if (cls != CLS_NOP) begin
            stat_nxt[Z_POS] = (acc_nxt == '0);
            stat_nxt[N_POS] = acc_nxt[N_POS];
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_mem,
    input  logic [1:0]        in_kind,
    output logic [DATA_W-1:0] out_acc,
    output logic [DATA_W-1:0] out_stat,
    output logic [DATA_W-1:0] out_x,
    output logic [DATA_W-1:0] out_y
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] xr;
        logic [DATA_W-1:0] yr;
        logic [DATA_W-1:0] stat;
        logic              pend_run;
        logic [OP_W-1:0]   pend_op;
        logic [DATA_W-1:0] pend_mem;
    } state_t;

    state_t st_d;
    state_t st_q;

    cls_e              pend_cls;
    logic [DATA_W-1:0] acc_nxt;
    logic [DATA_W-1:0] stat_nxt;

    acc_alu_decode u_decode (
        .op  (st_q.pend_op),
        .cls (pend_cls)
    );

    acc_alu_exec #(.DATA_W(DATA_W)) u_exec (
        .cls      (pend_cls),
        .acc      (st_q.acc),
        .stat     (st_q.stat),
        .mem      (st_q.pend_mem),
        .acc_nxt  (acc_nxt),
        .stat_nxt (stat_nxt)
    );

    always_comb begin
        st_d          = st_q;
        // capture stage: record taken this edge, executed on the next
        st_d.pend_run = (in_kind == KIND_EXEC);
        st_d.pend_op  = in_op;
        st_d.pend_mem = in_mem;
        // execute stage: the record captured on the previous edge
        if (st_q.pend_run) begin
            st_d.acc  = acc_nxt;
            st_d.stat = stat_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_acc  = st_q.acc;
    assign out_stat = st_q.stat;
    assign out_x    = st_q.xr;
    assign out_y    = st_q.yr;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   in_op,
    input logic [DATA_W-1:0] in_mem,
    input logic [1:0]        in_kind,
    input logic [DATA_W-1:0] out_acc,
    input logic [DATA_W-1:0] out_stat,
    input logic [DATA_W-1:0] out_x,
    input logic [DATA_W-1:0] out_y
);

    localparam int SUM_W = DATA_W + 1;
    localparam int N_POS = DATA_W - 1;

    // Checker's own copy of the record taken at the previous edge
    logic              v1;
    logic [1:0]        k1;
    logic [OP_W-1:0]   op1;
    logic [DATA_W-1:0] m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1  <= 1'b0;
            k1  <= 2'b00;
            op1 <= '0;
            m1  <= '0;
        end else begin
            v1  <= 1'b1;
            k1  <= in_kind;
            op1 <= in_op;
            m1  <= in_mem;
        end
    end

    logic run1;
    logic is_add1;
    logic is_and1;

    assign run1    = v1 && (k1 == 2'b01);
    assign is_add1 = (op1[OP_W-1:MODE_W] == GRP_ADD);
    assign is_and1 = (op1[OP_W-1:MODE_W] == GRP_AND);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_acc == '0 && out_stat == '0 && out_x == '0 && out_y == '0));

    // R2
    a_r2_add_carry: assert property (@(posedge clk) disable iff (rst)
        (run1 && is_add1) |=>
        ({out_stat[C_POS], out_acc} ==
         (SUM_W'($past(out_acc)) + SUM_W'($past(m1)) + SUM_W'($past(out_stat[C_POS])))));

    // R3
    a_r3_zero_neg: assert property (@(posedge clk) disable iff (rst)
        (run1 && (is_add1 || is_and1)) |=>
        (out_stat[Z_POS] == (out_acc == '0) && out_stat[N_POS] == out_acc[N_POS]));

    // R4
    a_r4_and_result: assert property (@(posedge clk) disable iff (rst)
        (run1 && is_and1) |=>
        (out_acc == ($past(out_acc) & $past(m1)) && $stable(out_stat[C_POS])));

    // R7, R8
    a_r7_hold_kind: assert property (@(posedge clk) disable iff (rst)
        (v1 && k1 != 2'b01) |=> ($stable(out_acc) && $stable(out_stat)));

    // R9
    a_r9_unknown_op: assert property (@(posedge clk) disable iff (rst)
        (run1 && !is_add1 && !is_and1) |=> ($stable(out_acc) && $stable(out_stat)));

    // R10
    a_r10_index_kept: assert property (@(posedge clk) disable iff (rst)
        v1 |=> ($stable(out_x) && $stable(out_y)));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .in_op    (in_op),
    .in_mem   (in_mem),
    .in_kind  (in_kind),
    .out_acc  (out_acc),
    .out_stat (out_stat),
    .out_x    (out_x),
    .out_y    (out_y)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_op = 8'h00;
    logic [7:0] in_mem = 8'h00;
    logic [1:0] in_kind = 2'b10;
    logic [7:0] out_acc, out_stat, out_x, out_y;

    acc_alu #(.DATA_W(8)) i_acc_alu (
        .clk(clk), .rst(rst), .in_op(in_op), .in_mem(in_mem), .in_kind(in_kind),
        .out_acc(out_acc), .out_stat(out_stat), .out_x(out_x), .out_y(out_y)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [7:0] OP_ADD = 8'h10;
    localparam logic [7:0] OP_AND = 8'h20;

    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_stat = 8'h00;
    logic [7:0] q1_op, q1_mem, q2_op, q2_mem;
    logic [1:0] q1_kind = 2'b10;
    logic [1:0] q2_kind = 2'b10;
    string      tag = "R1";

    task automatic chk(input string t, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", t, what, act, exp);
        end
    endtask

    task automatic model(input logic [7:0] op, input logic [7:0] mem, input logic [1:0] kind);
        logic [8:0] s;
        if (kind == 2'b01) begin
            if (op[7:3] == 5'b00010) begin
                s = {1'b0, m_acc} + {1'b0, mem} + {8'h00, m_stat[0]};
                m_acc = s[7:0];
                m_stat[0] = s[8];
                m_stat[1] = (m_acc == 8'h00);
                m_stat[7] = m_acc[7];
            end else if (op[7:3] == 5'b00100) begin
                m_acc = m_acc & mem;
                m_stat[1] = (m_acc == 8'h00);
                m_stat[7] = m_acc[7];
            end
        end
    endtask

    task automatic check_all();
        chk(tag, "acc", out_acc, m_acc);
        chk(tag, "stat", out_stat, m_stat);
        chk("R10", "x", out_x, 8'h00);
        chk("R10", "y", out_y, 8'h00);
    endtask

    // One record per cycle; the result compared now belongs to the record
    // driven two steps earlier (captured one edge, executed the next: R6).
    task automatic step(input logic [7:0] op, input logic [7:0] mem, input logic [1:0] kind);
        @(negedge clk);
        model(q2_op, q2_mem, q2_kind);
        check_all();
        q2_op = q1_op; q2_mem = q1_mem; q2_kind = q1_kind;
        q1_op = op;    q1_mem = mem;    q1_kind = kind;
        in_op = op; in_mem = mem; in_kind = kind;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_op = OP_ADD; in_mem = 8'hFF; in_kind = 2'b01;
        repeat (2) @(negedge clk);
        chk("R1", "acc", out_acc, 8'h00);
        chk("R1", "stat", out_stat, 8'h00);
        chk("R1", "x", out_x, 8'h00);
        chk("R1", "y", out_y, 8'h00);
        in_kind = 2'b10;
        @(negedge clk);
        rst = 1'b0;
        m_acc = 8'h00; m_stat = 8'h00;
        q1_op = in_op; q1_mem = in_mem; q1_kind = 2'b10;
        q2_op = in_op; q2_mem = in_mem; q2_kind = 2'b10;
    endtask

    task automatic drain();
        step(8'h00, 8'h00, 2'b10);
        step(8'h00, 8'h00, 2'b10);
    endtask

    initial begin
        q1_op = 8'h00; q1_mem = 8'h00; q2_op = 8'h00; q2_mem = 8'h00;
        do_reset();

        // R2, R3, R5: add sweep over accumulator, operand, carry, mode
        tag = "R2";
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 256; m++) begin
                step(OP_AND | 8'(m % 8), 8'h00, 2'b01);
                step(OP_ADD | 8'((m + 3) % 8), 8'(a * 17), 2'b01);
                step(OP_ADD | 8'((m + a) % 8), 8'(m), 2'b01);
            end
        end
        drain();

        // R4, R3, R5: AND sweep with carry set and clear beforehand
        tag = "R4";
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 256; m++) begin
                step(OP_AND | 8'(a % 8), 8'h00, 2'b01);
                step(OP_ADD | 8'(m % 8), 8'(a * 17 + 1), 2'b01);
                if (m[0]) step(OP_ADD, 8'hFF, 2'b01);
                step(OP_AND | 8'((m + 5) % 8), 8'(m), 2'b01);
            end
        end
        drain();

        // R6: one executed record in a run of idle ones
        tag = "R6";
        step(OP_AND, 8'h00, 2'b01);
        step(OP_ADD, 8'h5A, 2'b01);
        step(8'h00, 8'h00, 2'b10);
        step(8'h00, 8'h00, 2'b10);
        chk("R6", "acc_after_two_edges", out_acc, m_acc);

        // R7: present-only qualifier on valid operations
        tag = "R7";
        for (int i = 0; i < 64; i++) step((i[0] ? OP_AND : OP_ADD) | 8'(i % 8), 8'(i * 29), 2'b10);
        drain();
        chk("R7", "acc_kept", out_acc, 8'h5A);

        // R8: illegal qualifiers
        tag = "R8";
        for (int i = 0; i < 64; i++) step((i[1] ? OP_AND : OP_ADD) | 8'(i % 8), 8'(i * 13 + 7), i[0] ? 2'b11 : 2'b00);
        drain();
        chk("R8", "acc_kept", out_acc, 8'h5A);

        // R9: every opcode executed; only the two groups change state
        tag = "R9";
        for (int op = 0; op < 256; op++) begin
            step(8'(op), 8'(op * 37 + 11), 2'b01);
            if (op % 16 == 0) step(OP_ADD, 8'h3C, 2'b01);
        end
        drain();

        // R1: reset in the middle of activity
        step(OP_ADD, 8'hC7, 2'b01);
        step(OP_ADD, 8'hC7, 2'b01);
        drain();
        do_reset();
        tag = "R1";
        step(8'h00, 8'h00, 2'b10);
        drain();

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule